// File: doc/BRIEF.md
# UART Receive Character-Timeout Detector

This block watches the receive side of a UART whose received characters wait in a FIFO. When characters stay in the FIFO unread, it raises a character-timeout flag so that the host collects a short burst that never reached the FIFO's trigger level. The timer measures whole character times. A character time is worked out from the programmed frame format: start bit, data bits, optional parity bit and one or two stop bits. Each bit lasts a fixed number of ticks of the 16x baud-clock enable, so the delay follows the baud rate. At 300 baud with a 12-bit frame, the worst-case delay from the last character to the interrupt is about 160 ms.

Before the flag fires, either a newly received character or a host read of the FIFO restarts the timer. After the flag has fired, only a host read of one character clears it and restarts the timer. The timer does not run while the FIFO is empty, and the flag cannot be set then. The interrupt request is the flag, qualified by the FIFO-enable and receive-interrupt-enable bits. It is meant to be merged at the same priority level as the received-data-available interrupt.

Top module: `rx_char_timeout`

## Requirements
- R1: After reset, and for as long as `rst_n` is low, `to_pending` and `to_irq` are 0.
- R2: The frame length in bits is 7 + `word_len` + `parity_en` + `two_stop`. This comes from 1 start bit, `word_len` codes 0/1/2/3 meaning 5/6/7/8 data bits, 1 parity bit when enabled, and 1 or 2 stop bits. The timeout window is 4 x frame length x 16 ticks of `tick16`.
- R3: `to_pending` stays 0 up to and including the cycle after the window's second-to-last tick since the last restart. It goes to 1 in the cycle after the tick that completes the window.
- R4: Before the flag has fired, an `rx_push` pulse restarts the timer, and the full window must pass again.
- R5: Before the flag has fired, a `host_pop` pulse restarts the timer, and the full window must pass again.
- R6: Once `to_pending` is 1, it stays 1 through `rx_push` pulses and further ticks. A `host_pop` pulse clears it in the next cycle and restarts the timer.
- R7: While `fifo_level` is 0, the timer is held at zero. `to_pending` is 0 in the cycle after any cycle with `fifo_level` equal to 0, however many ticks arrive.
- R8: `to_irq` is 1 exactly when `to_pending`, `fifo_en` and `rx_int_en` are all 1.
- R9: A restart (`rx_push` or `host_pop`) in the same cycle as the tick that would complete the window wins. The flag stays 0, and a full new window is needed.
- R10: Clock cycles without `tick16` do not advance the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| word_len | input | 2 | Data-bit code: 0=5, 1=6, 2=7, 3=8 bits |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| rx_push | input | 1 | Pulse: a character was written into the receive FIFO |
| host_pop | input | 1 | Pulse: the host read one character from the receive FIFO |
| fifo_level | input | LEVEL_W | Current receive FIFO occupancy |
| fifo_en | input | 1 | FIFO mode enable |
| rx_int_en | input | 1 | Receive interrupt enable |
| to_pending | output | 1 | Character timeout has fired and is not yet cleared |
| to_irq | output | 1 | Timeout interrupt request |

## Verification
Two boundaries are hardest to reach from the ports. The first is the exact tick on which the window closes, which lies hundreds of ticks after the restart. The second is the race in which a restart lands on that very tick. The bench generates `tick16` itself, so it knows the exact tick count since every restart. It stops one tick short to check that the flag is still low, then applies the final tick either alone or together with a `host_pop` pulse. Both the prescaled and the flat counter variants run side by side on the same stimulus. This exposes any difference of one tick between the two counting schemes.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   localparam int unsigned MIN_FRAME_BITS = 7;
   localparam int unsigned MAX_FRAME_BITS = 12;
   localparam int unsigned FRAME_W        = $clog2(MAX_FRAME_BITS + 1);

   typedef enum logic [1:0] {
      DLEN_5 = 2'd0,
      DLEN_6 = 2'd1,
      DLEN_7 = 2'd2,
      DLEN_8 = 2'd3
   } dlen_e;

   // start + data (5..8) + optional parity + one or two stop bits
   function automatic logic [FRAME_W-1:0] frame_len(dlen_e dl, logic par, logic two);
      logic [FRAME_W-1:0] n;
      n = FRAME_W'(MIN_FRAME_BITS);
      n = n + FRAME_W'(dl);
      n = n + FRAME_W'(par);
      n = n + FRAME_W'(two);
      return n;
   endfunction

endpackage

// File: rtl/rxto_frame.sv
module rxto_frame #(
   parameter int TIMEOUT_CHARS = 4,
   parameter int LB_W          = 6
) (
   input  logic [1:0]      word_len,
   input  logic            parity_en,
   input  logic            two_stop,
   output logic [LB_W-1:0] limit_bits
);
   import rxto_pkg::*;

   logic [FRAME_W-1:0] fbits;

   assign fbits      = frame_len(dlen_e'(word_len), parity_en, two_stop);
   assign limit_bits = LB_W'(fbits) * LB_W'(TIMEOUT_CHARS);

endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
   parameter int TICKS_PER_BIT = 16,
   parameter int LB_W          = 6,
   parameter bit USE_PRESCALER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            run,
   input  logic            tick16,
   input  logic [LB_W-1:0] limit_bits,
   output logic            expire
);
   logic last;

   generate
      if (USE_PRESCALER) begin : g_pre
         localparam int SUB_W = $clog2(TICKS_PER_BIT);
         logic [SUB_W-1:0] sub_q;
         logic [LB_W-1:0]  bit_q;
         logic             sub_wrap;

         assign sub_wrap = (sub_q == SUB_W'(TICKS_PER_BIT - 1));
         assign last     = sub_wrap && (bit_q == limit_bits - LB_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub_q <= '0;
               bit_q <= '0;
            end else if (restart || !run || expire) begin
               sub_q <= '0;
               bit_q <= '0;
            end else if (tick16) begin
               if (sub_wrap) begin
                  sub_q <= '0;
                  bit_q <= bit_q + LB_W'(1);
               end else begin
                  sub_q <= sub_q + SUB_W'(1);
               end
            end
         end
      end else begin : g_flat
         localparam int LT_W = LB_W + $clog2(TICKS_PER_BIT) + 1;
         logic [LT_W-1:0] cnt_q;
         logic [LT_W-1:0] limit_ticks;

         assign limit_ticks = LT_W'(limit_bits) * LT_W'(TICKS_PER_BIT);
         assign last        = (cnt_q == limit_ticks - LT_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart || !run || expire) begin
               cnt_q <= '0;
            end else if (tick16) begin
               cnt_q <= cnt_q + LT_W'(1);
            end
         end
      end
   endgenerate

   assign expire = run && !restart && tick16 && last;

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic host_pop,
   input  logic empty,
   output logic pending
);
   logic pending_d;

   always_comb begin
      pending_d = pending;
      if (empty) begin
         pending_d = 1'b0;
      end else if (pending && host_pop) begin
         pending_d = 1'b0;
      end else if (expire) begin
         pending_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= pending_d;
   end

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout #(
   parameter int LEVEL_W       = 5,
   parameter int TIMEOUT_CHARS = 4,
   parameter int TICKS_PER_BIT = 16,
   parameter bit USE_PRESCALER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick16,
   input  logic [1:0]         word_len,
   input  logic               parity_en,
   input  logic               two_stop,
   input  logic               rx_push,
   input  logic               host_pop,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               fifo_en,
   input  logic               rx_int_en,
   output logic               to_pending,
   output logic               to_irq
);
   localparam int MAX_LIMIT_BITS = TIMEOUT_CHARS * int'(rxto_pkg::MAX_FRAME_BITS);
   localparam int LB_W           = $clog2(MAX_LIMIT_BITS + 1);

   if (TIMEOUT_CHARS < 1) begin : g_bad_chars
      $error("rx_char_timeout: TIMEOUT_CHARS must be at least 1");
   end
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("rx_char_timeout: TICKS_PER_BIT must be at least 2");
   end
   if (LEVEL_W < 1) begin : g_bad_level
      $error("rx_char_timeout: LEVEL_W must be at least 1");
   end

   logic [LB_W-1:0] limit_bits;
   logic            empty;
   logic            restart;
   logic            run;
   logic            expire;

   assign empty   = (fifo_level == '0);
   assign restart = empty || rx_push || host_pop;
   assign run     = !empty && !to_pending;

   rxto_frame #(
      .TIMEOUT_CHARS (TIMEOUT_CHARS),
      .LB_W          (LB_W)
   ) u_frame (
      .word_len   (word_len),
      .parity_en  (parity_en),
      .two_stop   (two_stop),
      .limit_bits (limit_bits)
   );

   rxto_timer #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .LB_W          (LB_W),
      .USE_PRESCALER (USE_PRESCALER)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .run        (run),
      .tick16     (tick16),
      .limit_bits (limit_bits),
      .expire     (expire)
   );

   rxto_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .host_pop (host_pop),
      .empty    (empty),
      .pending  (to_pending)
   );

   assign to_irq = to_pending && fifo_en && rx_int_en;

endmodule

// File: rtl/rx_char_timeout_chk.sv
module rx_char_timeout_chk #(
   parameter int LEVEL_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick16,
   input logic               rx_push,
   input logic               host_pop,
   input logic [LEVEL_W-1:0] fifo_level,
   input logic               fifo_en,
   input logic               rx_int_en,
   input logic               to_pending,
   input logic               to_irq
);
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      to_irq |-> to_pending);                                          // R8
   AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en || !rx_int_en) |-> !to_irq);                           // R8
   AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (to_pending && fifo_en && rx_int_en) |-> to_irq);                // R8
   AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == '0) |=> !to_pending);                             // R7
   AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (to_pending && host_pop) |=> !to_pending);                       // R6
   AST_PUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (to_pending && rx_push && !host_pop && fifo_level != '0) |=> to_pending); // R6
   AST_NO_RISE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_pending && !tick16) |=> !to_pending);                       // R10
   AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_pending && (rx_push || host_pop)) |=> !to_pending);         // R9

endmodule

bind rx_char_timeout rx_char_timeout_chk #(.LEVEL_W(LEVEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick16     (tick16),
   .rx_push    (rx_push),
   .host_pop   (host_pop),
   .fifo_level (fifo_level),
   .fifo_en    (fifo_en),
   .rx_int_en  (rx_int_en),
   .to_pending (to_pending),
   .to_irq     (to_irq)
);

// File: tb/tb_rx_char_timeout.sv
`timescale 1ns/1ps
module tb_rx_char_timeout;
   localparam int LEVEL_W = 5;
   localparam int WIN_CH  = 4;
   localparam int TPB     = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b0;
   logic [1:0] word_len = 2'd3;
   logic parity_en = 1'b0;
   logic two_stop = 1'b0;
   logic rx_push = 1'b0;
   logic host_pop = 1'b0;
   logic [LEVEL_W-1:0] fifo_level = '0;
   logic fifo_en = 1'b1;
   logic rx_int_en = 1'b1;
   logic pend_a, irq_a, pend_b, irq_b;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   rx_char_timeout #(.LEVEL_W(LEVEL_W), .USE_PRESCALER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_len(word_len),
      .parity_en(parity_en), .two_stop(two_stop), .rx_push(rx_push),
      .host_pop(host_pop), .fifo_level(fifo_level), .fifo_en(fifo_en),
      .rx_int_en(rx_int_en), .to_pending(pend_a), .to_irq(irq_a));

   rx_char_timeout #(.LEVEL_W(LEVEL_W), .USE_PRESCALER(1'b0)) dut_flat (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_len(word_len),
      .parity_en(parity_en), .two_stop(two_stop), .rx_push(rx_push),
      .host_pop(host_pop), .fifo_level(fifo_level), .fifo_en(fifo_en),
      .rx_int_en(rx_int_en), .to_pending(pend_b), .to_irq(irq_b));

   // {word_len[1:0], parity_en, two_stop, expected frame bits[3:0]}
   localparam logic [7:0] VEC [6] = '{
      {2'd0, 1'b0, 1'b0, 4'd7},
      {2'd3, 1'b1, 1'b1, 4'd12},
      {2'd3, 1'b0, 1'b0, 4'd10},
      {2'd2, 1'b1, 1'b0, 4'd10},
      {2'd1, 1'b0, 1'b1, 4'd9},
      {2'd0, 1'b1, 1'b1, 4'd9}
   };

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_pend(string req, logic exp);
      check({req, " prescaled"}, pend_a, exp);
      check({req, " flat"}, pend_b, exp);
   endtask

   task automatic check_irq(string req, logic exp);
      check({req, " irq prescaled"}, irq_a, exp);
      check({req, " irq flat"}, irq_b, exp);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick16 = 1'b1;
         @(negedge clk) tick16 = 1'b0;
      end
   endtask

   task automatic push();
      @(negedge clk) rx_push = 1'b1;
      @(negedge clk) rx_push = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk) host_pop = 1'b1;
      @(negedge clk) host_pop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lim;
      // R1 reset state
      repeat (3) @(negedge clk);
      check_pend("R1 reset", 1'b0);
      check_irq("R1 reset", 1'b0);
      rst_n = 1'b1;

      // Table walk: R2 R3 R6 R7 R8 per frame format
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         word_len   = VEC[v][7:6];
         parity_en  = VEC[v][5];
         two_stop   = VEC[v][4];
         fifo_level = 5'd1;
         lim = WIN_CH * int'(VEC[v][3:0]) * TPB;
         push();
         ticks(lim - 1);
         check_pend("R3 one tick short", 1'b0);
         ticks(1);
         check_pend("R2 window complete", 1'b1);
         check_irq("R8 enabled", 1'b1);
         pop();
         check_pend("R6 pop clears", 1'b0);
         ticks(lim - 1);
         check_pend("R6 restart after clear short", 1'b0);
         ticks(1);
         check_pend("R6 restart after clear fires", 1'b1);
         @(negedge clk) fifo_level = '0;
         @(negedge clk);
         check_pend("R7 empty clears", 1'b0);
      end

      // Directed, 8N1: 10 bits
      @(negedge clk);
      word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0; fifo_level = 5'd3;
      lim = WIN_CH * 10 * TPB;

      // R4 restart by received character
      push();
      ticks(lim - 10);
      push();
      ticks(lim - 1);
      check_pend("R4 push restarted", 1'b0);
      ticks(1);
      check_pend("R4 fires after full window", 1'b1);

      // R6 push while pending keeps the flag
      push();
      check_pend("R6 push keeps flag", 1'b1);
      ticks(5);
      check_pend("R6 ticks keep flag", 1'b1);

      // R8 gating
      @(negedge clk) fifo_en = 1'b0;
      @(negedge clk);
      check_irq("R8 fifo disabled", 1'b0);
      fifo_en = 1'b1; rx_int_en = 1'b0;
      @(negedge clk);
      check_irq("R8 rx int disabled", 1'b0);
      rx_int_en = 1'b1;
      @(negedge clk);
      check_irq("R8 re-enabled", 1'b1);

      // R5 restart by host read
      pop();
      check_pend("R6 pop clears directed", 1'b0);
      ticks(lim - 10);
      pop();
      ticks(lim - 1);
      check_pend("R5 pop restarted", 1'b0);
      ticks(1);
      check_pend("R5 fires after full window", 1'b1);

      // R7 no counting while empty
      @(negedge clk) fifo_level = '0;
      @(negedge clk);
      check_pend("R7 empty clears directed", 1'b0);
      ticks(lim + 5);
      check_pend("R7 ticks while empty", 1'b0);
      @(negedge clk) fifo_level = 5'd2;
      ticks(lim - 1);
      check_pend("R7 timer held at zero", 1'b0);
      ticks(1);
      check_pend("R7 counts once non-empty", 1'b1);

      // R9 restart on the completing tick wins
      pop();
      ticks(lim - 1);
      @(negedge clk); tick16 = 1'b1; host_pop = 1'b1;
      @(negedge clk); tick16 = 1'b0; host_pop = 1'b0;
      check_pend("R9 pop on final tick", 1'b0);
      ticks(lim - 1);
      check_pend("R9 full new window short", 1'b0);
      ticks(1);
      check_pend("R9 full new window fires", 1'b1);

      // R10 idle cycles do not count
      pop();
      ticks(lim - 1);
      repeat (50) @(negedge clk);
      check_pend("R10 idle cycles", 1'b0);
      ticks(1);
      check_pend("R10 final tick fires", 1'b1);

      // R1 reset mid-run
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      check_pend("R1 reset mid-run", 1'b0);
      check_irq("R1 reset mid-run", 1'b0);
      rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule